// File: doc/BRIEF.md
# Programmable periodic timer bank

A bank of independent down-counting timers, each reached through a single-cycle register bus. Every timer holds a period, a current count and a pending-interrupt flag, and drives one interrupt line. While its period is non-zero, a timer counts down by one per clock. When a step would bring the count to zero, the count reloads from the period and the pending flag sets. The line stays high until software clears it with a read of the timer's acknowledge slot. Counting carries on whether or not an interrupt is pending.

A period of zero turns a timer off. The count then runs down to zero and parks there, and no interrupt is raised. Writing zero to the period also drops any pending interrupt at once. Writing a non-zero period never restarts the count; the new period is only picked up at the next reload. Writing the count loads it directly, and any value is legal, including one above the period.

The bus address is `{timer index, slot[1:0]}`. The slots are: 0 = period, 1 = count, 2 = acknowledge, 3 = unused. A bus access completes in the cycle where `bus_sel` is high. Read data is combinational from the address, and register updates land on the clock edge that closes the access.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every period, count and pending flag is zero and every `irq` bit is low.
- R2: While a timer's period is non-zero and its count is above one, the count drops by exactly one on each rising clock edge.
- R3: While the period is non-zero and the count is one or zero (and no count write is in progress), the next edge loads the count with the period and sets the pending flag; `irq[i]` mirrors that flag, so a period P loaded with count P raises the interrupt after P edges and then every P edges.
- R4: A pending flag stays set until it is cleared by R5 or R8, and the count keeps moving while the flag is set.
- R5: A bus read (`bus_we`=0) of slot 2 of a timer clears its pending flag on that edge; a bus write to slot 2 changes no period, count or flag.
- R6: If an R3 reload and an R5 acknowledge read fall on the same edge, the pending flag ends up set.
- R7: While the period is zero the count decrements until it reaches zero and then holds at zero; no reload happens and the pending flag never sets.
- R8: A write of zero to slot 0 clears the pending flag on that edge, even when an R3 reload falls on the same edge.
- R9: A non-zero write to slot 0 leaves the count on its normal path; the new period is used at the next reload.
- R10: A write to slot 1 loads the count with the written data on that edge, taking priority over both decrement and reload; a count above the period then decrements normally.
- R11: `bus_rdata` shows the addressed timer's period for slot 0, its count for slot 1, and zero for slots 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+2 | Timer index in the upper bits, slot in the lower two |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for `bus_addr` |
| irq | output | NUM_TIMERS | One interrupt line per timer, high while pending |

## Verification
The bench sweeps every timer of a four-timer, 8-bit bank through periods one to six. At each edge it compares the count and the line against a closed form: the count is the period minus the edges elapsed modulo the period, and the line is set once a full period has passed. A reload that happens off by one cycle would shift that whole sequence.

Several edges where two events collide are driven on purpose:
- An acknowledge read on a reload edge. A design with the wrong priority loses the interrupt.
- A zero-period write on a reload edge. The wrong priority leaves a disabled timer with its line high.
- A count write on a reload edge. A design that lets the reload win shows the period instead of the written value.

A period rewrite in the middle of a count must not restart the count. Writes to the acknowledge slot must clear nothing.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  localparam int SLOT_W = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_PERIOD = 2'd0,
    SLOT_COUNT  = 2'd1,
    SLOT_ACK    = 2'd2,
    SLOT_SPARE  = 2'd3
  } slot_e;

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int IDX_W      = 2,
  localparam int ADDR_W    = IDX_W + SLOT_W
) (
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_TIMERS-1:0] per_wr,
  output logic [NUM_TIMERS-1:0] cnt_wr,
  output logic [NUM_TIMERS-1:0] ack_rd
);

  logic [IDX_W-1:0] idx;
  slot_e            slot;

  assign idx  = bus_addr[ADDR_W-1:SLOT_W];
  assign slot = slot_e'(bus_addr[SLOT_W-1:0]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
    logic hit;
    assign hit       = bus_sel && (idx == IDX_W'(i));
    assign per_wr[i] = hit &&  bus_we && (slot == SLOT_PERIOD);
    assign cnt_wr[i] = hit &&  bus_we && (slot == SLOT_COUNT);
    assign ack_rd[i] = hit && !bus_we && (slot == SLOT_ACK);
  end

endmodule

// File: rtl/tmr_bank_cell.sv
module tmr_bank_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_wr,
  input  logic             cnt_wr,
  input  logic             ack_rd,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] count_q,
  output logic             pending_q,
  output logic             wrap_evt,
  output logic             clr_evt
);

  // A step from this count lands on zero (or the count already sits there).
  function automatic logic at_floor(input logic [CNT_W-1:0] v);
    return v <= CNT_W'(1);
  endfunction

  // Free-running step: decrement, saturating at zero.
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  logic             enabled;
  logic [CNT_W-1:0] period_d;
  logic [CNT_W-1:0] count_d;
  logic             pending_d;

  always_comb begin
    enabled  = (period_q != '0);
    wrap_evt = enabled && !cnt_wr && at_floor(count_q);
    clr_evt  = per_wr && (wdata == '0);

    period_d = per_wr ? wdata : period_q;

    if (cnt_wr)        count_d = wdata;
    else if (wrap_evt) count_d = period_q;
    else               count_d = step_down(count_q);

    if (clr_evt)       pending_d = 1'b0;
    else if (wrap_evt) pending_d = 1'b1;
    else if (ack_rd)   pending_d = 1'b0;
    else               pending_d = pending_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= '0;
      count_q   <= '0;
      pending_q <= 1'b0;
    end else begin
      period_q  <= period_d;
      count_q   <= count_d;
      pending_q <= pending_d;
    end
  end

endmodule

// File: rtl/tmr_bank_rdmux.sv
module tmr_bank_rdmux
  import tmr_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = 2,
  localparam int ADDR_W    = IDX_W + SLOT_W
) (
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  period_all,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  count_all,
  output logic [CNT_W-1:0]                  rdata
);

  logic [IDX_W-1:0] idx;
  slot_e            slot;

  assign idx  = bus_addr[ADDR_W-1:SLOT_W];
  assign slot = slot_e'(bus_addr[SLOT_W-1:0]);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (idx == IDX_W'(i)) begin
        case (slot)
          SLOT_PERIOD: rdata = period_all[i];
          SLOT_COUNT:  rdata = count_all[i];
          default:     rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_bank_pkg::*;
#(
  parameter int  NUM_TIMERS = 4,
  parameter int  CNT_W      = 32,
  localparam int IDX_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W     = IDX_W + SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  output logic [NUM_TIMERS-1:0] irq
);

  // Named internal events, visible to the bound checker.
  logic [NUM_TIMERS-1:0]            per_wr;
  logic [NUM_TIMERS-1:0]            cnt_wr;
  logic [NUM_TIMERS-1:0]            ack_evt;
  logic [NUM_TIMERS-1:0]            wrap_evt;
  logic [NUM_TIMERS-1:0]            clr_evt;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] period_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] count_all;

  tmr_bank_decode #(
    .NUM_TIMERS (NUM_TIMERS),
    .IDX_W      (IDX_W)
  ) u_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .per_wr   (per_wr),
    .cnt_wr   (cnt_wr),
    .ack_rd   (ack_evt)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_cell
    tmr_bank_cell #(
      .CNT_W (CNT_W)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_wr    (per_wr[i]),
      .cnt_wr    (cnt_wr[i]),
      .ack_rd    (ack_evt[i]),
      .wdata     (bus_wdata),
      .period_q  (period_all[i]),
      .count_q   (count_all[i]),
      .pending_q (irq[i]),
      .wrap_evt  (wrap_evt[i]),
      .clr_evt   (clr_evt[i])
    );
  end

  tmr_bank_rdmux #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_rdmux (
    .bus_addr   (bus_addr),
    .period_all (period_all),
    .count_all  (count_all),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/tmr_bank_checker.sv
module tmr_bank_checker #(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [CNT_W-1:0]                bus_wdata,
  input logic [NUM_TIMERS-1:0]           irq,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] period_all,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] count_all,
  input logic [NUM_TIMERS-1:0]           cnt_wr,
  input logic [NUM_TIMERS-1:0]           wrap_evt,
  input logic [NUM_TIMERS-1:0]           ack_evt,
  input logic [NUM_TIMERS-1:0]           clr_evt
);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (period_all[i] != '0 && !cnt_wr[i] && count_all[i] > CNT_W'(1))
      |=> (count_all[i] == $past(count_all[i]) - CNT_W'(1)));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[i] && !clr_evt[i] |=> (count_all[i] == $past(period_all[i])) && irq[i]);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !ack_evt[i] && !clr_evt[i] |=> irq[i]);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt[i] && !wrap_evt[i] |=> !irq[i]);

    p_wrap_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt[i] && ack_evt[i] && !clr_evt[i] |=> irq[i]);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (period_all[i] == '0) && !irq[i] |=> !irq[i]);

    p_off_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (period_all[i] == '0) && !cnt_wr[i] && (count_all[i] == '0) |=> (count_all[i] == '0));

    p_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt[i] |=> !irq[i] && (period_all[i] == '0));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[i] |=> (count_all[i] == $past(bus_wdata)));

  end

endmodule

bind tick_timer_bank tmr_bank_checker #(
  .NUM_TIMERS (NUM_TIMERS),
  .CNT_W      (CNT_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .period_all (period_all),
  .count_all  (count_all),
  .cnt_wr     (cnt_wr),
  .wrap_evt   (wrap_evt),
  .ack_evt    (ack_evt),
  .clr_evt    (clr_evt)
);

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [N-1:0]  irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  tick_timer_bank #(.NUM_TIMERS(N), .CNT_W(W)) i_tick_timer_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] adr(input int t, input int slot);
    return AW'(t * 4 + slot);
  endfunction

  task automatic wr(input int t, input int slot, input int d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = adr(t, slot); bus_wdata = W'(d);
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic ack(input int t);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = adr(t, 2);
    tick();
    bus_sel = 1'b0;
  endtask

  // Read without an edge: combinational data, side-effect-free slots only.
  task automatic peek(input int t, input int slot, output int d);
    bus_addr = adr(t, slot);
    #0.5;
    d = int'(bus_rdata);
  endtask

  task automatic setup(input int t, input int p, input int v);
    wr(t, 0, 0);
    wr(t, 0, p);
    wr(t, 1, v);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    for (int t = 0; t < N; t++) begin
      peek(t, 0, d); check("R1 period", d, 0);
      peek(t, 1, d); check("R1 count", d, 0);
    end
    // R7 disabled timers stay silent at zero
    repeat (5) tick();
    check("R7 irq idle", int'(irq), 0);
    peek(2, 1, d); check("R7 count idle", d, 0);

    // R2/R3 sweep: count = P - (k mod P), irq once k >= P
    for (int t = 0; t < N; t++) begin
      for (int p = 1; p <= 6; p++) begin
        setup(t, p, p);
        for (int k = 0; k <= 2 * p + 1; k++) begin
          peek(t, 1, d);
          check("R2 R3 count", d, p - (k % p));
          check("R3 irq", int'(irq[t]), (k >= p) ? 1 : 0);
          tick();
        end
        peek(t, 0, d); check("R11 period read", d, p);
      end
    end
    peek(1, 3, d); check("R11 spare slot", d, 0);
    peek(1, 2, d); check("R11 ack slot", d, 0);

    // Acknowledge behaviour on timer 0
    setup(0, 3, 3);
    repeat (3) tick();
    check("R3 irq after period", int'(irq[0]), 1);
    ack(0);
    check("R5 ack clears", int'(irq[0]), 0);
    peek(0, 1, d); check("R4 counting across ack", d, 2);
    tick();
    peek(0, 1, d); check("R2 count before wrap", d, 1);
    ack(0);
    check("R6 wrap beats ack", int'(irq[0]), 1);
    peek(0, 1, d); check("R6 reload value", d, 3);
    wr(0, 2, 8'hFF);
    check("R5 ack write ignored", int'(irq[0]), 1);
    peek(0, 0, d); check("R5 period untouched", d, 3);
    peek(0, 1, d); check("R5 count untouched", d, 2);
    repeat (2) tick();
    check("R4 stays pending", int'(irq[0]), 1);
    peek(0, 1, d); check("R4 counting while pending", d, 3);

    // Period rewrite mid-count on timer 1, count above period
    setup(1, 3, 10);
    repeat (2) tick();
    peek(1, 1, d); check("R10 count above period", d, 8);
    wr(1, 0, 7);
    peek(1, 1, d); check("R9 no restart", d, 7);
    peek(1, 0, d); check("R9 period read", d, 7);
    repeat (6) tick();
    check("R9 no early irq", int'(irq[1]), 0);
    tick();
    check("R9 irq at wrap", int'(irq[1]), 1);
    peek(1, 1, d); check("R9 new period reload", d, 7);

    // Zero period clears and disables
    wr(1, 0, 0);
    check("R8 zero write clears", int'(irq[1]), 0);
    peek(1, 1, d); check("R7 count keeps falling", d, 6);
    repeat (6) tick();
    peek(1, 1, d); check("R7 reaches zero", d, 0);
    repeat (3) tick();
    peek(1, 1, d); check("R7 holds zero", d, 0);
    check("R7 no irq when off", int'(irq[1]), 0);

    // Zero period write on a reload edge
    setup(2, 2, 2);
    tick();
    wr(2, 0, 0);
    check("R8 clear beats wrap", int'(irq[2]), 0);
    repeat (3) tick();
    check("R8 stays clear", int'(irq[2]), 0);
    peek(2, 1, d); check("R7 off count floor", d, 0);

    // Count write on a reload edge
    setup(3, 4, 1);
    wr(3, 1, 5);
    check("R10 load beats wrap irq", int'(irq[3]), 0);
    peek(3, 1, d); check("R10 load value", d, 5);

    finish_run();
  end

endmodule